// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the two error counters a CAN node uses for fault confinement and works out the node's error state from them. Upstream logic classifies each transmission and reception and sends the result as a single-cycle strobe. The strobes are transmit error, transmit success, receive error (with a severity select), and receive success. The block updates its counters on the next clock edge. Its outputs are the counter values as read-only status and three mutually exclusive state flags: error-active, error-passive and bus-off.

The transmit counter is nine bits wide so that it can pass 255, which is the bus-off condition. Only its low byte is visible on the status output. The receive counter is eight bits wide and saturates. It has a special recovery rule: a successful reception while the counter is high reloads it to a fixed mid value instead of stepping it down. A bus-off node ignores all event strobes until a recovery request clears both counters.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counter outputs read 0 and only `err_active_o` is set.
- R2: A transmit error adds 8 to the 9-bit transmit counter. A transmit success subtracts 1, but never below 0. `tec_o` shows bits 7:0 of the counter.
- R3: A receive error adds 1 when `rx_err_major_i` is 0 and 8 when it is 1. The receive counter saturates at 255.
- R4: On a receive success, a receive counter above 128 is loaded with 120. Otherwise it goes down by 1, but never below 0 (so 128 becomes 127).
- R5: If an error strobe and a success strobe for the same counter arrive in the same cycle, only the error step is applied.
- R6: `err_passive_o` is 1 when either counter is above 127 and the node is not bus-off. `err_active_o` is 1 when neither counter is above 127 and the node is not bus-off. Exactly one of the three state flags is set at any time.
- R7: `bus_off_o` is 1 whenever the transmit counter is above 255.
- R8: While the node is bus-off, all error and success strobes leave both counters unchanged.
- R9: A recovery request clears both counters on the next edge and returns the node to error-active. It takes priority over every strobe arriving in the same cycle.
- R10: Every counter change appears on the outputs one clock after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Transmit success strobe |
| rx_err_i | input | 1 | Receive error strobe |
| rx_err_major_i | input | 1 | Severity for rx_err_i: 0 = step 1, 1 = step 8 |
| rx_ok_i | input | 1 | Receive success strobe |
| recover_i | input | 1 | Bus-off recovery request |
| tec_o | output | 8 | Low byte of the transmit error counter |
| rec_o | output | 8 | Receive error counter |
| err_active_o | output | 1 | Node is error-active |
| err_passive_o | output | 1 | Node is error-passive |
| bus_off_o | output | 1 | Node is bus-off |

## Verification
The assertions check a set of properties on every cycle:
- the state flags are one-hot;
- recovery always clears the counters;
- bus-off freezes both counters;
- the receive reload to 120 happens;
- the transmit and minor receive steps have the right size;
- the receive counter never underflows.

Other behaviours need the bench's scenarios to show them. These are saturation at 255, the boundary at exactly 128, the error-over-success priority, and the walk from error-active through error-passive to bus-off and back. Random traffic, biased toward errors, visits all three states many times, and a bench model checks every cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
   parameter int W            = 8,
   parameter int STEP_LO      = 1,
   parameter int STEP_HI      = 8,
   parameter int OK_STEP      = 1,
   parameter int SAT_MAX      = 255,
   parameter bit RELOAD_EN    = 1'b0,
   parameter int RELOAD_ABOVE = 128,
   parameter int RELOAD_VAL   = 120
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         hold,
   input  logic         err,
   input  logic         err_hi,
   input  logic         ok,
   output logic [W-1:0] cnt
);
   localparam int SW = W + 1;

   if (SAT_MAX >= (1 << W)) begin : g_bad_sat
      $error("fc_err_counter: SAT_MAX does not fit in W bits");
   end
   if (STEP_LO < 1 || STEP_HI < 1 || OK_STEP < 1) begin : g_bad_step
      $error("fc_err_counter: steps must be positive");
   end
   if (RELOAD_EN && RELOAD_VAL > RELOAD_ABOVE) begin : g_bad_reload
      $error("fc_err_counter: reload value must not exceed its threshold");
   end

   logic [SW-1:0] up_sum;
   logic [W-1:0]  up_val;
   logic [W-1:0]  dn_val;
   logic [W-1:0]  ok_val;
   logic [W-1:0]  cnt_d;

   always_comb begin
      up_sum = {1'b0, cnt} + (err_hi ? SW'(STEP_HI) : SW'(STEP_LO));
      up_val = (up_sum > SW'(SAT_MAX)) ? W'(SAT_MAX) : up_sum[W-1:0];
      dn_val = (cnt >= W'(OK_STEP)) ? cnt - W'(OK_STEP) : '0;
   end

   if (RELOAD_EN) begin : g_reload
      assign ok_val = (cnt > W'(RELOAD_ABOVE)) ? W'(RELOAD_VAL) : dn_val;
   end else begin : g_plain
      assign ok_val = dn_val;
   end

   always_comb begin
      if (clr)       cnt_d = '0;
      else if (hold) cnt_d = cnt;
      else if (err)  cnt_d = up_val;
      else if (ok)   cnt_d = ok_val;
      else           cnt_d = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end
endmodule

// File: rtl/fc_state_decode.sv
module fc_state_decode
   import can_fc_pkg::*;
#(
   parameter int TEC_W         = 9,
   parameter int REC_W         = 8,
   parameter int PASSIVE_ABOVE = 127,
   parameter int BUSOFF_ABOVE  = 255
) (
   input  logic [TEC_W-1:0] tec,
   input  logic [REC_W-1:0] rec,
   output fc_state_e        state,
   output logic             active,
   output logic             passive,
   output logic             busoff
);
   if (BUSOFF_ABOVE >= (1 << TEC_W) - 1) begin : g_bad_busoff
      $error("fc_state_decode: transmit counter cannot exceed bus-off limit");
   end
   if (PASSIVE_ABOVE >= BUSOFF_ABOVE) begin : g_bad_order
      $error("fc_state_decode: passive limit must sit below bus-off limit");
   end

   logic over_tx;
   logic over_rx;

   always_comb begin
      over_tx = tec > TEC_W'(PASSIVE_ABOVE);
      over_rx = {1'b0, rec} > (REC_W + 1)'(PASSIVE_ABOVE);
      if (tec > TEC_W'(BUSOFF_ABOVE)) state = FC_BUSOFF;
      else if (over_tx || over_rx)    state = FC_PASSIVE;
      else                            state = FC_ACTIVE;
      active  = (state == FC_ACTIVE);
      passive = (state == FC_PASSIVE);
      busoff  = (state == FC_BUSOFF);
   end
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
   parameter int TEC_W            = 9,
   parameter int REC_W            = 8,
   parameter int OUT_W            = 8,
   parameter int TX_ERR_STEP      = 8,
   parameter int TX_OK_STEP       = 1,
   parameter int RX_ERR_MINOR     = 1,
   parameter int RX_ERR_MAJOR     = 8,
   parameter int RX_OK_STEP       = 1,
   parameter int PASSIVE_ABOVE    = 127,
   parameter int BUSOFF_ABOVE     = 255,
   parameter int REC_RELOAD_ABOVE = 128,
   parameter int REC_RELOAD_VAL   = 120
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_err_i,
   input  logic             tx_ok_i,
   input  logic             rx_err_i,
   input  logic             rx_err_major_i,
   input  logic             rx_ok_i,
   input  logic             recover_i,
   output logic [OUT_W-1:0] tec_o,
   output logic [REC_W-1:0] rec_o,
   output logic             err_active_o,
   output logic             err_passive_o,
   output logic             bus_off_o
);
   localparam int TEC_MAX = (1 << TEC_W) - 1;
   localparam int REC_MAX = (1 << REC_W) - 1;

   if (OUT_W > TEC_W) begin : g_bad_out
      $error("can_fault_counters: status byte wider than transmit counter");
   end
   if (REC_RELOAD_ABOVE >= REC_MAX) begin : g_bad_rec
      $error("can_fault_counters: reload threshold out of receive range");
   end

   logic [TEC_W-1:0] tec_cnt;
   logic [REC_W-1:0] rec_cnt;
   logic             busoff;
   can_fc_pkg::fc_state_e node_state;

   fc_err_counter #(
      .W(TEC_W), .STEP_LO(TX_ERR_STEP), .STEP_HI(TX_ERR_STEP),
      .OK_STEP(TX_OK_STEP), .SAT_MAX(TEC_MAX), .RELOAD_EN(1'b0),
      .RELOAD_ABOVE(0), .RELOAD_VAL(0)
   ) u_tx_cnt (
      .clk(clk), .rst_n(rst_n), .clr(recover_i), .hold(busoff),
      .err(tx_err_i), .err_hi(1'b0), .ok(tx_ok_i), .cnt(tec_cnt)
   );

   fc_err_counter #(
      .W(REC_W), .STEP_LO(RX_ERR_MINOR), .STEP_HI(RX_ERR_MAJOR),
      .OK_STEP(RX_OK_STEP), .SAT_MAX(REC_MAX), .RELOAD_EN(1'b1),
      .RELOAD_ABOVE(REC_RELOAD_ABOVE), .RELOAD_VAL(REC_RELOAD_VAL)
   ) u_rx_cnt (
      .clk(clk), .rst_n(rst_n), .clr(recover_i), .hold(busoff),
      .err(rx_err_i), .err_hi(rx_err_major_i), .ok(rx_ok_i), .cnt(rec_cnt)
   );

   fc_state_decode #(
      .TEC_W(TEC_W), .REC_W(REC_W),
      .PASSIVE_ABOVE(PASSIVE_ABOVE), .BUSOFF_ABOVE(BUSOFF_ABOVE)
   ) u_decode (
      .tec(tec_cnt), .rec(rec_cnt), .state(node_state),
      .active(err_active_o), .passive(err_passive_o), .busoff(busoff)
   );

   assign bus_off_o = busoff;
   assign tec_o     = tec_cnt[OUT_W-1:0];
   assign rec_o     = rec_cnt;
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
   parameter int TEC_W = 9,
   parameter int REC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_err_i,
   input logic             tx_ok_i,
   input logic             rx_err_i,
   input logic             rx_err_major_i,
   input logic             rx_ok_i,
   input logic             recover_i,
   input logic [REC_W-1:0] rec_o,
   input logic             err_active_o,
   input logic             err_passive_o,
   input logic             bus_off_o,
   input logic [TEC_W-1:0] tec_full
);
   AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({err_active_o, err_passive_o, bus_off_o}) == 1); // R6
   AST_RECOVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      recover_i |=> (tec_full == '0 && rec_o == '0 && err_active_o)); // R9
   AST_BUSOFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off_o && !recover_i) |=> ($stable(tec_full) && $stable(rec_o))); // R8
   AST_REC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ok_i && !rx_err_i && !recover_i && !bus_off_o && rec_o > 8'd128)
      |=> rec_o == 8'd120); // R4
   AST_REC_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_o == '0 && !rx_err_i) |=> rec_o == '0); // R4
   AST_REC_MINOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_err_i && !rx_err_major_i && !recover_i && !bus_off_o && rec_o != '1)
      |=> rec_o == $past(rec_o) + 1'b1); // R3
   AST_TX_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_err_i && !recover_i && !bus_off_o)
      |=> tec_full == $past(tec_full) + TEC_W'(8)); // R2
   AST_BUSOFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off_o == (tec_full > TEC_W'(255))); // R7
endmodule

bind can_fault_counters can_fc_checker #(.TEC_W(TEC_W), .REC_W(REC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i),
   .rx_err_i(rx_err_i), .rx_err_major_i(rx_err_major_i), .rx_ok_i(rx_ok_i),
   .recover_i(recover_i), .rec_o(rec_o), .err_active_o(err_active_o),
   .err_passive_o(err_passive_o), .bus_off_o(bus_off_o), .tec_full(tec_cnt)
);

// File: tb/can_fault_counters_tb_top.sv
`timescale 1ns/1ps
module can_fault_counters_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_major = 0, rx_ok = 0, recover = 0;
   logic [7:0] tec_o, rec_o;
   logic act, pas, boff;
   int checks = 0;
   int errors = 0;
   int mt = 0;
   int mr = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   can_fault_counters dut_i (
      .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
      .rx_err_i(rx_err), .rx_err_major_i(rx_major), .rx_ok_i(rx_ok),
      .recover_i(recover), .tec_o(tec_o), .rec_o(rec_o),
      .err_active_o(act), .err_passive_o(pas), .bus_off_o(boff)
   );

   function automatic int next_tec(int t, bit te, bit to);
      if (te) return t + 8;
      if (to) return (t > 0) ? t - 1 : 0;
      return t;
   endfunction

   function automatic int next_rec(int r, bit re, bit rm, bit ro);
      int s;
      if (re) begin
         s = r + (rm ? 8 : 1);
         return (s > 255) ? 255 : s;
      end
      if (ro) return (r > 128) ? 120 : ((r > 0) ? r - 1 : 0);
      return r;
   endfunction

   task automatic compare(string req);
      bit eb = (mt > 255);
      bit ep = !eb && (mt > 127 || mr > 127);
      bit ea = !eb && !ep;
      checks++;
      if (tec_o !== 8'(mt % 256) || rec_o !== 8'(mr) ||
          act !== ea || pas !== ep || boff !== eb) begin
         errors++;
         $display("FAIL %s: tec=%0d rec=%0d a/p/b=%b%b%b expected tec=%0d rec=%0d a/p/b=%b%b%b",
                  req, tec_o, rec_o, act, pas, boff, mt % 256, mr, ea, ep, eb);
      end
   endtask

   task automatic expect_val(string req, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic step(bit te, bit to, bit re, bit rm, bit ro, bit rc, string req);
      tx_err = te; tx_ok = to; rx_err = re; rx_major = rm; rx_ok = ro; recover = rc;
      @(posedge clk);
      if (rc) begin
         mt = 0; mr = 0;
      end else if (mt <= 255) begin
         mt = next_tec(mt, te, to);
         mr = next_rec(mr, re, rm, ro);
      end
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      expect_val("R1 active", int'(act), 1);

      repeat (3) step(1, 0, 0, 0, 0, 0, "R2 tx error");
      expect_val("R2 tec +8", int'(tec_o), 24);
      step(0, 1, 0, 0, 0, 0, "R2 tx ok");
      expect_val("R10 tec -1", int'(tec_o), 23);
      step(1, 1, 0, 0, 0, 0, "R5 tx both");
      expect_val("R5 tx error wins", int'(tec_o), 31);
      repeat (40) step(0, 1, 0, 0, 0, 0, "R2 floor");
      expect_val("R2 floor at 0", int'(tec_o), 0);

      step(0, 0, 1, 1, 0, 0, "R3 major");
      step(0, 0, 1, 0, 0, 0, "R3 minor");
      expect_val("R3 steps", int'(rec_o), 9);
      step(0, 0, 1, 0, 1, 0, "R5 rx both");
      expect_val("R5 rx error wins", int'(rec_o), 10);
      repeat (17) step(0, 0, 1, 1, 0, 0, "R6 to passive");
      expect_val("R6 passive", int'(pas), 1);
      step(0, 0, 0, 0, 1, 0, "R4 reload");
      expect_val("R4 reload to 120", int'(rec_o), 120);
      step(0, 0, 1, 1, 0, 0, "R4 to 128");
      step(0, 0, 0, 0, 1, 0, "R4 boundary");
      expect_val("R4 128 steps to 127", int'(rec_o), 127);
      expect_val("R6 back active", int'(act), 1);
      repeat (20) step(0, 0, 1, 1, 0, 0, "R3 saturate");
      expect_val("R3 saturate at 255", int'(rec_o), 255);

      step(0, 0, 0, 0, 0, 1, "R9 recover");
      repeat (32) step(1, 0, 0, 0, 0, 0, "R7 climb");
      expect_val("R7 bus-off", int'(boff), 1);
      step(0, 0, 1, 1, 0, 0, "R8 rx err ignored");
      step(1, 0, 0, 0, 0, 0, "R8 tx err ignored");
      step(0, 1, 0, 0, 1, 0, "R8 ok ignored");
      expect_val("R8 tec frozen", int'(tec_o), 0);
      step(1, 0, 1, 1, 0, 1, "R9 recover priority");
      expect_val("R9 active after recovery", int'(act), 1);
      expect_val("R9 rec cleared", int'(rec_o), 0);

      for (int i = 0; i < 4000; i++) begin
         bit te = ($urandom % 100) < 30;
         bit to = ($urandom % 100) < 25;
         bit re = ($urandom % 100) < 30;
         bit rm = ($urandom % 2) == 1;
         bit ro = ($urandom % 100) < 30;
         bit rc = ($urandom % 48) == 0;
         step(te, to, re, rm, ro, rc, "R6 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule